// File: doc/BRIEF.md
# Two-Level Lookahead Arithmetic-Logic Unit with Set-Less-Than

This block is a 32-bit arithmetic-logic unit assembled from identical one-bit slices. Each slice works out a generate term, a propagate term, a sum bit and a selected result bit. Slices are grouped by four under a carry-lookahead unit to form a 4-bit unit. Four of those 4-bit units sit under a second lookahead unit to form a 16-bit unit. Two 16-bit halves are then joined by a single ripple carry.

The caller controls the operation with a 2-bit operation code, an invert-b flag and a carry-in. Add, subtract, bitwise AND, bitwise OR and set-less-than all come from these three controls. To subtract, or to compare, the caller raises both invert-b and carry-in so that the adder forms a − b. For set-less-than, the sum bit of slice 31 is routed back to the "less" input of slice 0. All other less inputs are held at zero.

The combinational result is captured in one output register, so the result appears one clock after the operands.

Top module: `lookahead_alu32`

## Requirements
- R1: With op = 2'b00, the result is (a + b_eff + carry_in) modulo 2^32, where b_eff is b when inv_b is 0 and ~b when inv_b is 1.
- R2: With op = 2'b00, inv_b = 1 and carry_in = 1, the result is a − b modulo 2^32.
- R3: With op = 2'b01, the result is the bitwise AND of a and b_eff.
- R4: With op = 2'b10, the result is the bitwise OR of a and b_eff.
- R5: With op = 2'b11, result bit 0 equals bit 31 of (a + b_eff + carry_in), and bits 31..1 are zero.
- R6: With op = 2'b11, inv_b = 1 and carry_in = 1, result bit 0 follows only the sign bit of the wrapped a − b. Signed overflow is ignored, so a = 0x7FFFFFFF with b = 0xFFFFFFFF gives 1.
- R7: Carries propagate across every 4-bit and 16-bit boundary. For example, 0xFFFFFFFF + 1 gives 0, and 0x0000FFFF + 1 gives 0x00010000.
- R8: While rst_n is low the result is 0.
- R9: The result reflects the inputs present at the previous rising clock edge, and it does not change between edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the result register updates on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the result register |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| inv_b | input | 1 | When 1, the complement of b is used in place of b |
| carry_in | input | 1 | Carry into bit 0 |
| op | input | 2 | Operation: 00 arithmetic, 01 AND, 10 OR, 11 set-less-than |
| result | output | 32 | Registered result |

## Verification
Random operands, random controls and all four operation codes check the whole datapath against a reference sum and the reference logic functions. Directed carry chains tell apart a correct lookahead hierarchy from one that drops a carry at a 4-bit or 16-bit boundary or at the ripple join. Comparison pairs that straddle the signed range show that set-less-than takes the raw sign of the difference and does not correct for overflow. A sample taken just after new operands are driven, before the next edge, tells apart a registered result from one that follows its inputs directly.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int SLICES_PER_UNIT = 4;

    typedef enum logic [1:0] {
        OP_ARITH = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_SLT   = 2'b11
    } alu_op_e;
endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic    a,
    input  logic    b,
    input  logic    cin,
    input  logic    inv_b,
    input  alu_op_e op,
    input  logic    less,
    output logic    g,
    output logic    p,
    output logic    sum,
    output logic    res
);
    logic b_eff;

    always_comb begin
        b_eff = b ^ inv_b;
        g     = a & b_eff;
        p     = a | b_eff;
        sum   = a ^ b_eff ^ cin;
        unique case (op)
            OP_ARITH: res = sum;
            OP_AND:   res = g;
            OP_OR:    res = p;
            default:  res = less;
        endcase
    end
endmodule

// File: rtl/cla_unit.sv
module cla_unit (
    input  logic [3:0] g,
    input  logic [3:0] p,
    input  logic       cin,
    output logic [3:0] c,
    output logic       gg,
    output logic       pg
);
    always_comb begin
        c[0] = cin;
        c[1] = g[0] | (p[0] & cin);
        c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
        c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
             | (p[2] & p[1] & p[0] & cin);
        gg   = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
             | (p[3] & p[2] & p[1] & g[0]);
        pg   = &p;
    end
endmodule

// File: rtl/alu_unit4.sv
module alu_unit4
    import alu_pkg::*;
#(
    parameter int W = SLICES_PER_UNIT
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         inv_b,
    input  alu_op_e      op,
    input  logic [W-1:0] less,
    output logic [W-1:0] sum,
    output logic [W-1:0] res,
    output logic         gg,
    output logic         pg
);
    logic [W-1:0] g, p, c;

    for (genvar i = 0; i < W; i++) begin : g_slice
        alu_slice u_slice (
            .a(a[i]), .b(b[i]), .cin(c[i]), .inv_b(inv_b), .op(op),
            .less(less[i]), .g(g[i]), .p(p[i]), .sum(sum[i]), .res(res[i])
        );
    end

    cla_unit u_cla (.g(g), .p(p), .cin(cin), .c(c), .gg(gg), .pg(pg));
endmodule

// File: rtl/alu_unit16.sv
module alu_unit16
    import alu_pkg::*;
#(
    parameter int SUB = SLICES_PER_UNIT,
    localparam int W  = SUB * 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         inv_b,
    input  alu_op_e      op,
    input  logic [W-1:0] less,
    output logic [W-1:0] sum,
    output logic [W-1:0] res,
    output logic         gg,
    output logic         pg
);
    logic [3:0] ug, up, uc;

    for (genvar k = 0; k < 4; k++) begin : g_unit
        alu_unit4 #(.W(SUB)) u_unit (
            .a(a[k*SUB +: SUB]), .b(b[k*SUB +: SUB]), .cin(uc[k]),
            .inv_b(inv_b), .op(op), .less(less[k*SUB +: SUB]),
            .sum(sum[k*SUB +: SUB]), .res(res[k*SUB +: SUB]),
            .gg(ug[k]), .pg(up[k])
        );
    end

    cla_unit u_cla (.g(ug), .p(up), .cin(cin), .c(uc), .gg(gg), .pg(pg));
endmodule

// File: rtl/lookahead_alu32.sv
module lookahead_alu32
    import alu_pkg::*;
#(
    parameter int UNIT = SLICES_PER_UNIT,
    localparam int HALF = UNIT * 4,
    localparam int W    = HALF * 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_b,
    input  logic         carry_in,
    input  logic [1:0]   op,
    output logic [W-1:0] result
);
    typedef struct packed {
        logic [W-1:0] res;
    } state_t;

    state_t       st_d, st_q;
    logic [W-1:0] sum_w, res_w, less_w;
    logic         g_lo, p_lo, g_hi, p_hi, mid_c;
    alu_op_e      op_e;

    assign op_e   = alu_op_e'(op);
    assign mid_c  = g_lo | (p_lo & carry_in);
    assign less_w = {{(W-1){1'b0}}, sum_w[W-1]};

    alu_unit16 #(.SUB(UNIT)) u_lo (
        .a(a[HALF-1:0]), .b(b[HALF-1:0]), .cin(carry_in), .inv_b(inv_b),
        .op(op_e), .less(less_w[HALF-1:0]), .sum(sum_w[HALF-1:0]),
        .res(res_w[HALF-1:0]), .gg(g_lo), .pg(p_lo)
    );

    alu_unit16 #(.SUB(UNIT)) u_hi (
        .a(a[W-1:HALF]), .b(b[W-1:HALF]), .cin(mid_c), .inv_b(inv_b),
        .op(op_e), .less(less_w[W-1:HALF]), .sum(sum_w[W-1:HALF]),
        .res(res_w[W-1:HALF]), .gg(g_hi), .pg(p_hi)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = res_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result = st_q.res;

    logic [W-1:0] b_ref;
    assign b_ref = inv_b ? ~b : b;

    AST_ARITH_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b00) |->
        result == $past(a + b_ref + W'(carry_in)));  // R1
    AST_SUBTRACT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b00 && $past(inv_b) && $past(carry_in)) |->
        result == $past(a - b));  // R2
    AST_AND_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b01) |-> result == $past(a & b_ref));  // R3
    AST_OR_FUNC: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b10) |-> result == $past(a | b_ref));  // R4
    AST_SLT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b11) |-> result[W-1:1] == '0);  // R5
    AST_SLT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op) == 2'b11 && $past(inv_b) && $past(carry_in)) |->
        result[0] == $past(((a - b) >> (W-1)) & W'(1)) != '0);  // R6
    AST_RESET_ZERO: assert property (@(posedge clk)
        $past(rst_n) == 1'b0 && $past(rst_n, 2) == 1'b0 |-> result == '0);  // R8
endmodule

// File: tb/sim_lookahead_alu32.sv
module sim_lookahead_alu32;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a = '0, b = '0;
    logic        inv_b = 1'b0, carry_in = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    lookahead_alu32 u0 (
        .clk(clk), .rst_n(rst_n), .a(a), .b(b), .inv_b(inv_b),
        .carry_in(carry_in), .op(op), .result(result)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] ref_alu(input logic [31:0] x, input logic [31:0] y,
                                            input logic iv, input logic ci,
                                            input logic [1:0] o);
        logic [31:0] ye, s;
        ye = iv ? ~y : y;
        s  = x + ye + {31'b0, ci};
        case (o)
            2'b00:   return s;
            2'b01:   return x & ye;
            2'b10:   return x | ye;
            default: return {31'b0, s[31]};
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run(input string req, input logic [31:0] x, input logic [31:0] y,
                       input logic iv, input logic ci, input logic [1:0] o);
        logic [31:0] prev;
        @(negedge clk);
        prev = result;
        a = x; b = y; inv_b = iv; carry_in = ci; op = o;
        #1;
        check("R9 hold", result, prev);
        @(negedge clk);
        check(req, result, ref_alu(x, y, iv, ci, o));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd381));
        a = 32'hDEAD_BEEF; b = 32'h1234_5678; op = 2'b00;
        repeat (3) @(negedge clk);
        check("R8 reset", result, 32'h0);
        rst_n = 1'b1;

        run("R1 add", 32'h0000_0005, 32'h0000_0003, 1'b0, 1'b0, 2'b00);
        run("R1 add with carry", 32'h1000_0000, 32'h0000_0001, 1'b0, 1'b1, 2'b00);
        run("R2 sub", 32'h0000_0003, 32'h0000_0005, 1'b1, 1'b1, 2'b00);
        run("R7 full carry", 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b00);
        run("R7 half boundary", 32'h0000_FFFF, 32'h0000_0001, 1'b0, 1'b0, 2'b00);
        run("R7 nibble boundary", 32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0, 2'b00);
        run("R3 and", 32'hF0F0_AAAA, 32'hFF00_5555, 1'b0, 1'b0, 2'b01);
        run("R3 and inverted", 32'hF0F0_AAAA, 32'hFF00_5555, 1'b1, 1'b0, 2'b01);
        run("R4 or", 32'h1200_0034, 32'h0056_7800, 1'b0, 1'b0, 2'b10);
        run("R4 or inverted", 32'h0000_0000, 32'h0F0F_0F0F, 1'b1, 1'b0, 2'b10);
        run("R5 slt less", 32'h0000_0002, 32'h0000_0009, 1'b1, 1'b1, 2'b11);
        run("R5 slt not less", 32'h0000_0009, 32'h0000_0002, 1'b1, 1'b1, 2'b11);
        run("R5 slt equal", 32'h1234_5678, 32'h1234_5678, 1'b1, 1'b1, 2'b11);
        run("R6 slt overflow pos", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b1, 2'b11);
        run("R6 slt overflow neg", 32'h8000_0000, 32'h0000_0001, 1'b1, 1'b1, 2'b11);

        for (int i = 0; i < 3000; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            case (o)
                2'b00:   run("R1 random arith", $urandom, $urandom, 1'($urandom), 1'($urandom), o);
                2'b01:   run("R3 random and", $urandom, $urandom, 1'($urandom), 1'($urandom), o);
                2'b10:   run("R4 random or", $urandom, $urandom, 1'($urandom), 1'($urandom), o);
                default: run("R5 random slt", $urandom, $urandom, 1'($urandom), 1'($urandom), o);
            endcase
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 reset again", result, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule